// File: doc/BRIEF.md
# Run-Time Partitioned SIMD Adder

This block adds two operand words that can be divided at run time into independent integer lanes. The word is cut into equal slots of `LANE` bits. A boundary-enable vector picks which slot boundaries are lane edges, so one call can add one wide integer, several narrow ones, or a mix of widths on slot-aligned edges. Each lane takes its own carry-in and gives its own carry-out.

Internally there is one wide adder. A spacer bit sits at every possible slot boundary, and one extra bit sits at each end. At an enabled boundary the spacer stops the carry coming from the lane below and starts the lane above with that lane's carry-in. It also catches the carry-out of the lane below. At a disabled boundary the spacer passes the carry straight through. The data result is the wide sum with all spacer bits and both end bits removed.

The block is purely combinational, with no clock and no state. The defaults are a 32-bit word in four 8-bit slots.

Top module: `padd_top`

## Requirements
- R1: When no boundary is enabled (bits `N-2..0` of `part_en_i` all 0), `{cout_o[0], sum_o}` equals `a_i + b_i + cin_i[0]` over the full width.
- R2: Bit k of `part_en_i` (k < N-1) makes bit `(k+1)*LANE` the first bit of a new lane. Each lane's bits of `sum_o` equal the low bits of that lane's slice of `a_i` plus the same slice of `b_i` plus the lane's carry-in.
- R3: A lane's carry-in is `cin_i[j]`, where slot j is the lane's lowest slot. Its carry-out appears on `cout_o[j]`. Slot j covers bits `j*LANE` to `j*LANE+LANE-1`.
- R4: Every bit of `cout_o` at a slot that does not start a lane is 0. Slot 0 always starts a lane. Slot j > 0 starts a lane when `part_en_i[j-1]` is 1.
- R5: Bits of `cin_i` at slots that do not start a lane have no effect on `sum_o` or `cout_o`.
- R6: The top bit `part_en_i[N-1]` has no effect on `sum_o` or `cout_o`.
- R7: No carry crosses an enabled boundary: a lane whose slice overflows does not change the lane above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand word |
| b_i | input | W | Second operand word |
| part_en_i | input | N (W/LANE) | Boundary enables; bit k cuts at bit (k+1)*LANE; top bit unused |
| cin_i | input | N | Carry-in per slot; used only at lane-start slots |
| sum_o | output | W | Lane-wise sums |
| cout_o | output | N | Carry-out per lane, placed at the lane's lowest slot |

## Verification
The block holds no state, so any internal fault shows at the ports at once, for the same input pattern. A spacer bit at the wrong level at an enabled boundary would corrupt the lowest bit of the lane above, or that lane's carry-out. At a disabled boundary it would break carry propagation inside a wider lane. If the carry-out steering were wrong, a carry would show up at a slot that does not start a lane, or land in the wrong lane's slot. The sweep covers every boundary pattern and every carry-in pattern, with both saturating and mixed operands, so each of these faults changes an output value.

// File: rtl/padd_pkg.sv
`timescale 1ns/1ps
package padd_pkg;
    // Position of data bit i in the expanded word: one bit at the bottom
    // for the first carry-in plus one spacer per completed slot below it.
    function automatic int data_pos(input int i, input int lane);
        return 1 + i + i / lane;
    endfunction

    // Position of the spacer that sits at the bottom of slot k (k >= 1).
    function automatic int spacer_pos(input int k, input int lane);
        return k * (lane + 1);
    endfunction
endpackage

// File: rtl/padd_expand.sv
`timescale 1ns/1ps
module padd_expand
    import padd_pkg::*;
#(
    parameter  int W    = 32,
    parameter  int LANE = 8,
    localparam int N    = W / LANE,
    localparam int EW   = W + N + 1
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [N-2:0]  bnd_en,
    input  logic [N-1:0]  cin,
    output logic [EW-1:0] ea,
    output logic [EW-1:0] eb
);
    // bottom end bit: twice the first carry-in gives a carry into bit 1
    assign ea[0] = cin[0];
    assign eb[0] = cin[0];
    // top end bit collects the carry-out of the uppermost lane
    assign ea[EW-1] = 1'b0;
    assign eb[EW-1] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_data
        assign ea[data_pos(i, LANE)] = a[i];
        assign eb[data_pos(i, LANE)] = b[i];
    end

    // spacer at an enabled boundary: both bits = carry-in of the upper lane,
    // so the lower carry lands in the spacer and the upper lane starts fresh.
    // spacer at a disabled boundary: 1 + 0 propagates the carry unchanged.
    for (genvar k = 1; k < N; k++) begin : g_spacer
        assign ea[spacer_pos(k, LANE)] = bnd_en[k-1] ? cin[k] : 1'b1;
        assign eb[spacer_pos(k, LANE)] = bnd_en[k-1] & cin[k];
    end
endmodule

// File: rtl/padd_wide.sv
`timescale 1ns/1ps
module padd_wide #(
    parameter int EW = 37
) (
    input  logic [EW-1:0] ea,
    input  logic [EW-1:0] eb,
    output logic [EW-1:0] es
);
    // top bits of both operands are zero, so the sum never wraps
    assign es = ea + eb;
endmodule

// File: rtl/padd_extract.sv
`timescale 1ns/1ps
module padd_extract
    import padd_pkg::*;
#(
    parameter  int W    = 32,
    parameter  int LANE = 8,
    localparam int N    = W / LANE,
    localparam int EW   = W + N + 1
) (
    input  logic [EW-1:0] es,
    input  logic [N-2:0]  bnd_en,
    output logic [W-1:0]  sum,
    output logic [N-1:0]  cout
);
    logic unused_lsb;
    assign unused_lsb = es[0];

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = es[data_pos(i, LANE)];
    end

    // Each slot sees the carry caught just above it (spacer or top bit),
    // whether it ends a lane, and whether it starts one. A downward chain
    // hands the carry of the nearest lane end to every slot beneath it.
    for (genvar s = N - 1; s >= 0; s--) begin : g_slot
        logic caught;
        logic ends_here;
        logic starts_here;
        logic pend;
        if (s == N - 1) begin : g_top
            assign caught    = es[EW-1];
            assign ends_here = 1'b1;
            assign pend      = caught;
        end else begin : g_mid
            assign caught    = es[spacer_pos(s + 1, LANE)];
            assign ends_here = bnd_en[s];
            assign pend      = ends_here ? caught : g_slot[s+1].pend;
        end
        if (s == 0) begin : g_first
            assign starts_here = 1'b1;
        end else begin : g_rest
            assign starts_here = bnd_en[s-1];
        end
        assign cout[s] = starts_here & pend;
    end
endmodule

// File: rtl/padd_top.sv
`timescale 1ns/1ps
module padd_top #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [W/LANE-1:0] part_en_i,
    input  logic [W/LANE-1:0] cin_i,
    output logic [W-1:0]      sum_o,
    output logic [W/LANE-1:0] cout_o
);
    localparam int N  = W / LANE;
    localparam int EW = W + N + 1;

    logic [EW-1:0] ea;
    logic [EW-1:0] eb;
    logic [EW-1:0] es;
    logic [N-2:0]  bnd_en;
    logic          unused_top_en;

    assign bnd_en        = part_en_i[N-2:0];
    assign unused_top_en = part_en_i[N-1];

    padd_expand #(.W(W), .LANE(LANE)) u_expand (
        .a      (a_i),
        .b      (b_i),
        .bnd_en (bnd_en),
        .cin    (cin_i),
        .ea     (ea),
        .eb     (eb)
    );

    padd_wide #(.EW(EW)) u_wide (
        .ea (ea),
        .eb (eb),
        .es (es)
    );

    padd_extract #(.W(W), .LANE(LANE)) u_extract (
        .es     (es),
        .bnd_en (bnd_en),
        .sum    (sum_o),
        .cout   (cout_o)
    );
endmodule

// File: rtl/padd_chk.sv
`timescale 1ns/1ps
module padd_chk #(
    parameter int W    = 32,
    parameter int LANE = 8
) (
    input logic [W-1:0]      a_i,
    input logic [W-1:0]      b_i,
    input logic [W/LANE-1:0] part_en_i,
    input logic [W/LANE-1:0] cin_i,
    input logic [W-1:0]      sum_o,
    input logic [W/LANE-1:0] cout_o
);
    localparam int N = W / LANE;

    logic [N-1:0] starts;
    logic [W:0]   full;
    logic         unused_chk_top;

    assign starts         = {part_en_i[N-2:0], 1'b1};
    assign full           = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i[0]};
    assign unused_chk_top = part_en_i[N-1];

    always_comb begin
        AST_COUT_AT_LANE_START: assert ((cout_o & ~starts) == '0)
            else $error("carry-out at a non-start slot"); // R4
        AST_ZERO_OPERANDS_NO_CARRY: assert (!(a_i == '0 && b_i == '0) || cout_o == '0)
            else $error("carry-out from zero operands"); // R3
        AST_FULL_WIDTH_SUM: assert (part_en_i[N-2:0] != '0 || {cout_o[0], sum_o} == full)
            else $error("unpartitioned sum mismatch"); // R1
        AST_ADD_ZERO_IDENTITY: assert (!(b_i == '0 && (cin_i & starts) == '0)
                                       || (sum_o == a_i && cout_o == '0))
            else $error("adding zero changed the operand"); // R2
    end
endmodule

bind padd_top padd_chk #(.W(W), .LANE(LANE)) u_chk (.*);

// File: tb/sim_padd_top.sv
`timescale 1ns/1ps
module sim_padd_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // small configuration: 8-bit word, four 2-bit slots
    logic [7:0]  a0, b0, s0;
    logic [3:0]  p0, c0, co0;
    // default configuration: 32-bit word, four 8-bit slots
    logic [31:0] a1, b1, s1;
    logic [3:0]  p1, c1, co1;

    padd_top #(.W(8), .LANE(2)) u0 (
        .a_i(a0), .b_i(b0), .part_en_i(p0), .cin_i(c0), .sum_o(s0), .cout_o(co0));
    padd_top u1 (
        .a_i(a1), .b_i(b1), .part_en_i(p1), .cin_i(c1), .sum_o(s1), .cout_o(co1));

    // arithmetic lane model: walk lanes, add slices, split off the carry
    function automatic void model(input int lane, input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] pe, input logic [3:0] cin,
                                  output logic [31:0] es, output logic [3:0] ec);
        int st;
        es = '0;
        ec = '0;
        st = 0;
        for (int s = 0; s < 4; s++) begin
            if (s == 3 || pe[s]) begin
                int len;
                int lo;
                longint m;
                longint v;
                len = (s - st + 1) * lane;
                lo  = st * lane;
                m   = (longint'(1) << len) - 1;
                v   = (longint'(a >> lo) & m) + (longint'(b >> lo) & m) + longint'(cin[st]);
                es  = es | (32'(v & m) << lo);
                ec[st] = 1'(v >> len);
                st  = s + 1;
            end
        end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive0(input logic [3:0] p, input logic [3:0] c,
                          input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        p0 = p; c0 = c; a0 = a; b0 = b;
        @(posedge clk);
        #1;
    endtask

    task automatic drive1(input logic [3:0] p, input logic [3:0] c,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        p1 = p; c1 = c; a1 = a; b1 = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] es;
        logic [3:0]  ec;
        logic [3:0]  sm;
        a0 = '0; b0 = '0; p0 = '0; c0 = '0;
        a1 = '0; b1 = '0; p1 = '0; c1 = '0;

        // idle pattern on the wide instance: all zero in, all zero out
        drive1(4'b0000, 4'b0000, 32'h0, 32'h0);
        chk("R1 idle sum", s1, 32'h0);
        chk("R3 idle cout", 32'(co1), 32'h0);

        // sweep of the small configuration
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [7:0] a;
                    logic [7:0] b;
                    if (k == 0) begin
                        a = 8'hFF; b = 8'h55;
                    end else if (k == 1) begin
                        a = 8'hFF; b = 8'hFF;
                    end else begin
                        a = 8'(k * 73 + p * 11 + c * 5);
                        b = 8'(k * 151 + c * 29 + 8'h35);
                    end
                    sm = {4'(p) & 4'b0111, 1'b1} ;
                    model(2, 32'(a), 32'(b), 4'(p), 4'(c), es, ec);

                    drive0(4'(p), 4'(c), a, b);
                    if (p == 0) chk("R1 full-width sum", 32'(s0), es);
                    else        chk("R2 lane sums", 32'(s0), es);
                    chk("R3 lane carry-out", 32'(co0), 32'(ec));
                    chk("R4 non-start carry-out zero", 32'(co0 & ~sm), 32'h0);

                    // flip carry-ins at slots that start no lane
                    drive0(4'(p), 4'(c) ^ ~sm, a, b);
                    chk("R5 ignored carry-in sum", 32'(s0), es);
                    chk("R5 ignored carry-in cout", 32'(co0), 32'(ec));

                    // set the unused top enable bit
                    drive0(4'(p) | 4'b1000, 4'(c), a, b);
                    chk("R6 top enable sum", 32'(s0), es);
                    chk("R6 top enable cout", 32'(co0), 32'(ec));
                end
            end
        end

        // carry isolation on the wide instance
        drive1(4'b0111, 4'b0000, 32'hFFFF_FFFF, 32'h0101_0101);
        chk("R7 four byte lanes sum", s1, 32'h0000_0000);
        chk("R7 four byte lanes cout", 32'(co1), 32'h0000_000F);

        drive1(4'b0000, 4'b0000, 32'hFFFF_FFFF, 32'h0101_0101);
        chk("R1 one 32-bit lane sum", s1, 32'h0101_0100);
        chk("R1 one 32-bit lane cout", 32'(co1), 32'h0000_0001);

        drive1(4'b0101, 4'b0000, 32'hFFFF_FFFF, 32'h0000_0001);
        chk("R7 8/16/8 lanes sum", s1, 32'hFFFF_FF00);
        chk("R7 8/16/8 lanes cout", 32'(co1), 32'h0000_0001);

        drive1(4'b0101, 4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        chk("R3 middle lane carry-in sum", s1, 32'hFF00_0000);
        chk("R3 middle lane carry-in cout", 32'(co1), 32'h0000_0003);

        drive1(4'b0101, 4'b0100, 32'hFFFF_FFFF, 32'h0000_0001);
        chk("R5 carry-in inside lane ignored sum", s1, 32'hFFFF_FF00);
        chk("R5 carry-in inside lane ignored cout", 32'(co1), 32'h0000_0001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule